// File: doc/BRIEF.md
# Dual-Core Boot Source Selector

This block decides, at reset time, which memory region the primary core boots from, and it controls when the secondary core is allowed to start. The primary core's region is chosen from a boot pin and three option bits. A pin-selected main-flash boot falls back to system memory when main flash is marked empty. The empty mark is refreshed from the first flash word each time the options are reloaded, and software may also write it.

The secondary core is held until software sets a boot-enable bit. That bit survives a standby period and is cleared only by a main reset. The secondary core's start address is the option-supplied vector. When the options are invalid and the primary core boots from main flash, a fixed safe vector replaces it.

The boot inputs are captured only at defined moments: the first clock after reset release, a standby exit, or an option reload. Between those moments the selection outputs hold their values, whatever the inputs do.

Top module: `boot_sel_ctrl`

## Requirements
- R1: While `rst_n` is low, `boot_region` is 2'b00, `empty_flag` is 0, `c2_release` is 0 and `c2_boot_addr` is 0.
- R2: With `opt_nswboot0`=1 the effective select bit is `boot_pin`. A select bit of 0 gives main flash (2'b00). A select bit of 1 gives system memory (2'b01) when `opt_nboot1`=1, and SRAM1 (2'b10) when `opt_nboot1`=0. The code 2'b11 never appears.
- R3: With `opt_nswboot0`=0 the effective select bit is the inverse of `opt_nboot0`, and `boot_pin` has no effect. The region mapping is the one given in R2.
- R4: When `opt_nswboot0`=1, `boot_pin`=0 and the empty flag is 1 at the capture, system memory (2'b01) is selected.
- R5: When `opt_nswboot0`=0 and `opt_nboot0`=1, main flash is selected whatever the empty flag is.
- R6: On an `opt_load` cycle, `empty_flag` becomes 1 on the next cycle if `flash_word0` is all ones, and 0 otherwise.
- R7: A `sw_empty_we` cycle writes `sw_empty_wd` into `empty_flag` on the next cycle. When it coincides with `opt_load`, the flash word wins.
- R8: `boot_region` and `c2_boot_addr` are recaptured only on the first cycle after reset release, on `stby_exit` and on `opt_load`, and each result appears on the following cycle. A capture on `opt_load` uses the newly loaded empty value.
- R9: `c2_release` is a registered copy of the boot-enable bit. It rises one cycle after the bit is set, which is two edges after the `sw_c2en_we` cycle, and it falls in the same way after the bit is cleared.
- R10: A `stby_exit` cycle leaves the boot-enable bit unchanged and forces `c2_release` low for exactly the following cycle, after which it follows the bit again.
- R11: A main reset clears the boot-enable bit, so `c2_release` stays low after reset until software sets the bit again.
- R12: At capture, `c2_boot_addr` takes `opt_c2_vec`, unless `opt_valid`=0 and the selected region is main flash; in that case it takes the safe vector (default 32'h0804_F000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Main reset, asynchronous, active low |
| boot_pin | input | 1 | External boot select pin |
| opt_nboot1 | input | 1 | Option bit choosing system memory (1) or SRAM1 (0) |
| opt_nboot0 | input | 1 | Option bit used as the inverted select bit in software mode |
| opt_nswboot0 | input | 1 | 1: pin selects, 0: option bit selects |
| opt_c2_vec | input | AW | Secondary-core boot vector from options |
| opt_valid | input | 1 | Options passed their validity check |
| flash_word0 | input | DW | First main-flash word read during option loading |
| opt_load | input | 1 | One-cycle option reload event |
| stby_exit | input | 1 | One-cycle standby exit event |
| sw_empty_we | input | 1 | Software write strobe for the empty flag |
| sw_empty_wd | input | 1 | Software value for the empty flag |
| sw_c2en_we | input | 1 | Software write strobe for the secondary boot enable |
| sw_c2en_wd | input | 1 | Software value for the secondary boot enable |
| boot_region | output | 2 | 00 main flash, 01 system memory, 10 SRAM1 |
| empty_flag | output | 1 | Main flash considered empty |
| c2_release | output | 1 | Secondary core released from hold |
| c2_boot_addr | output | AW | Secondary-core start address |

## Verification
The hardest case to reach is the empty-flash fallback. It applies only to a pin-driven main-flash choice, and the empty value must be the one in force at the capture, not an older one. The stimulus reaches it in three ways: an option reload whose flash word is all ones, a software write of the flag followed by a standby exit, and a reload that coincides with a software write so that the priority between the two is exercised. A standby exit while the secondary core is enabled is also driven, to show the one-cycle drop in the release and that the enable bit is kept.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  typedef enum logic [1:0] {
    REG_MAIN = 2'b00,
    REG_SYS  = 2'b01,
    REG_SRAM = 2'b10
  } boot_region_t;

  // Effective select bit: pin in pin mode, inverted option bit otherwise.
  function automatic logic eff_select(input logic pin, input logic nsw, input logic nb0);
    return nsw ? pin : ~nb0;
  endfunction

  // Region from the select bit; the empty fallback applies only in pin mode.
  function automatic boot_region_t pick_region(input logic sel, input logic nb1,
                                               input logic pin_mode, input logic empty);
    boot_region_t r;
    if (!sel) r = (pin_mode && empty) ? REG_SYS : REG_MAIN;
    else      r = nb1 ? REG_SYS : REG_SRAM;
    return r;
  endfunction

endpackage

// File: rtl/boot_decode.sv
module boot_decode
  import boot_sel_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] SAFE_VEC = 32'h0804_F000
) (
  input  logic          pin,
  input  logic          nsw,
  input  logic          nb0,
  input  logic          nb1,
  input  logic          empty,
  input  logic          valid,
  input  logic [AW-1:0] vec,
  output boot_region_t  region,
  output logic [AW-1:0] c2_addr,
  output logic          safe_taken
);

  logic sel;

  always_comb begin
    sel        = eff_select(pin, nsw, nb0);
    region     = pick_region(sel, nb1, nsw, empty);
    safe_taken = !valid && (region == REG_MAIN);
    c2_addr    = safe_taken ? SAFE_VEC : vec;
  end

  // R2: no reserved region code is ever produced
  always_comb begin
    a_r2_legal_code: assert (region != 2'b11);
  end

endmodule

// File: rtl/empty_tracker.sv
module empty_tracker #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          opt_load,
  input  logic [DW-1:0] flash_word,
  input  logic          sw_we,
  input  logic          sw_wd,
  output logic          empty_q,
  output logic          empty_next
);

  localparam logic [DW-1:0] ERASED = {DW{1'b1}};

  logic word_erased;

  always_comb begin
    word_erased = (flash_word == ERASED);
    if (opt_load)   empty_next = word_erased;
    else if (sw_we) empty_next = sw_wd;
    else            empty_next = empty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b0;
    else        empty_q <= empty_next;
  end

  // R6: a reload of an erased word marks flash empty
  a_r6_load_erased: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_load && flash_word == ERASED) |=> empty_q);
  // R6: a reload of a programmed word clears the mark
  a_r6_load_programmed: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_load && flash_word != ERASED) |=> !empty_q);
  // R7: without any update the flag keeps its value
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!opt_load && !sw_we) |=> $stable(empty_q));

endmodule

// File: rtl/c2_gate.sv
module c2_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_we,
  input  logic en_wd,
  input  logic stby_exit,
  output logic en_q,
  output logic release_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      release_q <= 1'b0;
    end else begin
      if (en_we) en_q <= en_wd;
      release_q <= en_q && !stby_exit;
    end
  end

  // R9: an enabled core is released on the next cycle
  a_r9_release_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !stby_exit) |=> release_q);
  // R9: no release without the enable bit
  a_r9_no_release_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !release_q);
  // R10: standby exit drops the release for one cycle
  a_r10_stby_drop: assert property (@(posedge clk) disable iff (!rst_n)
    stby_exit |=> !release_q);
  // R10: standby exit leaves the enable bit alone
  a_r10_en_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_exit && !en_we) |=> $stable(en_q));

endmodule

// File: rtl/boot_sel_ctrl.sv
module boot_sel_ctrl
  import boot_sel_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] SAFE_VEC = 32'h0804_F000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_pin,
  input  logic          opt_nboot1,
  input  logic          opt_nboot0,
  input  logic          opt_nswboot0,
  input  logic [AW-1:0] opt_c2_vec,
  input  logic          opt_valid,
  input  logic [DW-1:0] flash_word0,
  input  logic          opt_load,
  input  logic          stby_exit,
  input  logic          sw_empty_we,
  input  logic          sw_empty_wd,
  input  logic          sw_c2en_we,
  input  logic          sw_c2en_wd,
  output logic [1:0]    boot_region,
  output logic          empty_flag,
  output logic          c2_release,
  output logic [AW-1:0] c2_boot_addr
);

  logic          started_q;
  logic          sample_evt;
  logic          empty_next;
  boot_region_t  region_next;
  boot_region_t  region_q;
  logic [AW-1:0] addr_next;
  logic [AW-1:0] addr_q;
  logic          safe_taken;
  logic          c2_en_q;

  assign sample_evt = !started_q || stby_exit || opt_load;

  empty_tracker #(.DW(DW)) u_empty (
    .clk        (clk),
    .rst_n      (rst_n),
    .opt_load   (opt_load),
    .flash_word (flash_word0),
    .sw_we      (sw_empty_we),
    .sw_wd      (sw_empty_wd),
    .empty_q    (empty_flag),
    .empty_next (empty_next)
  );

  boot_decode #(.AW(AW), .SAFE_VEC(SAFE_VEC)) u_dec (
    .pin        (boot_pin),
    .nsw        (opt_nswboot0),
    .nb0        (opt_nboot0),
    .nb1        (opt_nboot1),
    .empty      (empty_next),
    .valid      (opt_valid),
    .vec        (opt_c2_vec),
    .region     (region_next),
    .c2_addr    (addr_next),
    .safe_taken (safe_taken)
  );

  c2_gate u_c2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_we     (sw_c2en_we),
    .en_wd     (sw_c2en_wd),
    .stby_exit (stby_exit),
    .en_q      (c2_en_q),
    .release_q (c2_release)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      region_q  <= REG_MAIN;
      addr_q    <= '0;
    end else begin
      started_q <= 1'b1;
      if (sample_evt) begin
        region_q <= region_next;
        addr_q   <= addr_next;
      end
    end
  end

  assign boot_region  = region_q;
  assign c2_boot_addr = addr_q;

  // R8: selection holds between capture events
  a_r8_region_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_evt |=> ($stable(boot_region) && $stable(c2_boot_addr)));
  // R4: pin-mode main flash with an empty mark goes to system memory
  a_r4_empty_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && opt_nswboot0 && !boot_pin && empty_next) |=> (boot_region == 2'b01));
  // R5: forced main flash ignores the empty mark
  a_r5_forced_main: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && !opt_nswboot0 && opt_nboot0) |=> (boot_region == 2'b00));
  // R12: invalid options with main flash pick the safe vector
  a_r12_safe_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && safe_taken) |=> (c2_boot_addr == SAFE_VEC));
  // R11: the release is low on the first cycle after reset
  a_r11_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |-> !c2_release);

endmodule

// File: tb/sim_boot_sel_ctrl.sv
`timescale 1ns/1ps
module sim_boot_sel_ctrl;

  localparam logic [31:0] SAFE = 32'h0804_F000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_pin = 0, opt_nboot1 = 1, opt_nboot0 = 1, opt_nswboot0 = 1, opt_valid = 1;
  logic [31:0] opt_c2_vec = 32'h2000_0100;
  logic [31:0] flash_word0 = 32'h1234_5678;
  logic opt_load = 0, stby_exit = 0, sw_empty_we = 0, sw_empty_wd = 0, sw_c2en_we = 0, sw_c2en_wd = 0;
  logic [1:0]  boot_region;
  logic        empty_flag, c2_release;
  logic [31:0] c2_boot_addr;

  always #2 clk = ~clk;

  boot_sel_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .opt_nboot1(opt_nboot1),
    .opt_nboot0(opt_nboot0), .opt_nswboot0(opt_nswboot0), .opt_c2_vec(opt_c2_vec),
    .opt_valid(opt_valid), .flash_word0(flash_word0), .opt_load(opt_load),
    .stby_exit(stby_exit), .sw_empty_we(sw_empty_we), .sw_empty_wd(sw_empty_wd),
    .sw_c2en_we(sw_c2en_we), .sw_c2en_wd(sw_c2en_wd), .boot_region(boot_region),
    .empty_flag(empty_flag), .c2_release(c2_release), .c2_boot_addr(c2_boot_addr)
  );

  int    n_checks = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  // Behavioural reference state
  int          m_region = 0;
  bit          m_empty = 0, m_en = 0, m_rel = 0, m_first = 1;
  logic [31:0] m_addr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_region = 0; m_empty = 0; m_en = 0; m_rel = 0; m_first = 1; m_addr = 0;
    end else begin
      bit nxt_empty, capture, pick;
      int reg_v;
      nxt_empty = m_empty;
      if (sw_empty_we) nxt_empty = sw_empty_wd;
      if (opt_load) nxt_empty = (flash_word0 == 32'hFFFF_FFFF);
      capture = m_first || stby_exit || opt_load;
      if (capture) begin
        if (opt_nswboot0 == 1'b1) pick = boot_pin;
        else pick = (opt_nboot0 == 1'b0);
        case ({pick, opt_nboot1})
          2'b11:   reg_v = 1;
          2'b10:   reg_v = 2;
          default: reg_v = (opt_nswboot0 && nxt_empty) ? 1 : 0;
        endcase
        m_region = reg_v;
        m_addr = (reg_v == 0 && !opt_valid) ? SAFE : opt_c2_vec;
      end
      m_rel = m_en && !stby_exit;
      if (sw_c2en_we) m_en = sw_c2en_wd;
      m_empty = nxt_empty;
      m_first = 0;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk("boot_region", {30'd0, boot_region}, m_region);
      chk("empty_flag", {31'd0, empty_flag}, {31'd0, m_empty});
      chk("c2_release", {31'd0, c2_release}, {31'd0, m_rel});
      chk("c2_boot_addr", c2_boot_addr, m_addr);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; step(2); rst_n = 1; step(2);
  endtask

  task automatic pulse_stby();
    @(negedge clk); stby_exit = 1; @(negedge clk); stby_exit = 0; step(2);
  endtask

  task automatic pulse_load(input logic [31:0] w);
    @(negedge clk); flash_word0 = w; opt_load = 1; @(negedge clk); opt_load = 0; step(2);
  endtask

  task automatic wr_en(input logic v);
    @(negedge clk); sw_c2en_we = 1; sw_c2en_wd = v; @(negedge clk); sw_c2en_we = 0; step(2);
  endtask

  initial begin
    cur_req = "R1"; step(3);
    rst_n = 1; step(2);

    cur_req = "R2";
    opt_nswboot0 = 1; boot_pin = 0; do_reset();
    boot_pin = 1; opt_nboot1 = 1; pulse_stby();
    opt_nboot1 = 0; pulse_stby();

    cur_req = "R3";
    opt_nswboot0 = 0; opt_nboot0 = 0; boot_pin = 0; opt_nboot1 = 1; pulse_stby();
    boot_pin = 1; opt_nboot0 = 1; pulse_stby();
    boot_pin = 0; opt_nboot0 = 0; opt_nboot1 = 0; pulse_stby();

    cur_req = "R6";
    pulse_load(32'hFFFF_FFFF);
    pulse_load(32'hFFFF_FFFE);

    cur_req = "R4";
    opt_nswboot0 = 1; boot_pin = 0; opt_nboot1 = 1; pulse_load(32'hFFFF_FFFF);

    cur_req = "R5";
    opt_nswboot0 = 0; opt_nboot0 = 1; pulse_stby();

    cur_req = "R7";
    opt_nswboot0 = 1; boot_pin = 0;
    @(negedge clk); sw_empty_we = 1; sw_empty_wd = 0; @(negedge clk); sw_empty_we = 0; step(1);
    pulse_stby();
    @(negedge clk); sw_empty_we = 1; sw_empty_wd = 1; @(negedge clk); sw_empty_we = 0; step(1);
    pulse_stby();
    @(negedge clk); sw_empty_we = 1; sw_empty_wd = 1; flash_word0 = 32'h0; opt_load = 1;
    @(negedge clk); sw_empty_we = 0; opt_load = 0; step(2);

    cur_req = "R8";
    boot_pin = 1; opt_nboot1 = 0; opt_valid = 0; opt_c2_vec = 32'h1000_0040; step(5);
    opt_nswboot0 = 0; opt_nboot0 = 0; step(3);

    cur_req = "R9";
    wr_en(1); step(3); wr_en(0); step(2); wr_en(1);

    cur_req = "R10";
    pulse_stby(); step(3);

    cur_req = "R11";
    do_reset(); step(3); wr_en(1);

    cur_req = "R12";
    opt_nswboot0 = 1; boot_pin = 0; opt_valid = 0; opt_c2_vec = 32'h2000_0200; pulse_load(32'h0);
    boot_pin = 1; opt_nboot1 = 1; pulse_stby();
    boot_pin = 0; opt_valid = 1; pulse_stby();
    opt_valid = 0; opt_c2_vec = 32'h0800_1000; do_reset();

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule